// File: doc/BRIEF.md
# Duplicated Register/Counter with Load Code Check

This block keeps two copies of a loadable down-counter. An external word and its Berger check bits come in on a load command. The word is written into both copies. The check bits are written only next to the first copy. In the cycle after the load, a zero-counting adder tree rebuilds the check bits from the second copy's contents. A two-rail comparator tree then matches them against the stored bits. A wrong load, a corrupted code word, or a fault in either copy therefore shows up before any counting starts.

The first copy drives the value output and a zero flag for the sequencing logic that uses the count. The second copy drives an inverted zero flag, so the two flags form a two-rail pair for a checker further down the line. On a decrement both copies step down together. The stored check bits are then out of date, so no code check is made on those cycles.

Top module: `dup_regcnt`

## Requirements
- R1: After reset, valueOut is 0, zeroA is 1, nonZeroB is 0 and chkPair is 2'b01.
- R2: When loadEn is high at a rising clock edge, extData is written into both copies and appears on valueOut after that edge. loadEn takes precedence over decEn.
- R3: When decEn is high and loadEn is low at an edge, both copies decrease by one, and 0 wraps to all ones.
- R4: When neither loadEn nor decEn is high, both copies keep their value.
- R5: The check bits are the count of zero bits in the DATA_W-bit word, as an unsigned binary number. At the second edge after a load edge, chkPair has complementary bits (01 or 10) if extChk equalled the zero count of extData, and equal bits (00 or 11) if it did not.
- R6: At every edge that does not directly follow a load edge, chkPair is set to 2'b01, including after decrements, whose stale check bits are never compared.
- R7: zeroA is 1 exactly when the first copy is 0. nonZeroB is 1 exactly when the second copy is not 0. In fault-free operation the two are complementary.
- R8: Flipping any single bit of an otherwise correct extChk makes the following check report equal bits on chkPair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| loadEn | input | 1 | Load extData/extChk into the copies |
| decEn | input | 1 | Decrement both copies |
| extData | input | DATA_W (12) | External information word |
| extChk | input | CHK_W (4) | Berger check bits of extData (zero count) |
| valueOut | output | DATA_W (12) | Contents of the first copy |
| zeroA | output | 1 | First copy is zero |
| nonZeroB | output | 1 | Second copy is non-zero (two-rail partner of zeroA) |
| chkPair | output | 2 | Two-rail load check result: complementary means clean |

## Verification
On every cycle the assertions check four things: load, decrement and hold move both copies in step; the idle code on chkPair outside check cycles; the complementary zero rails; and check cycles occurring only right after a load. Whether the adder tree counts zeros correctly, and whether the comparator tree turns a single flipped code bit into equal rails, shows only in the bench's scenarios. Those scenarios load words with correct check bits, with wrong check bits, and with each check bit flipped in turn.

// File: rtl/dup_regcnt_pkg.sv
package dup_regcnt_pkg;
  typedef struct packed {
    logic load;       // capture external word into both copies
    logic dec;        // decrement both copies
    logic checkLive;  // this cycle compares the stored and rebuilt code
  } rcStrobe_t;
endpackage

// File: rtl/berger_zero_count.sv
// Zero-count generator built as a balanced tree of adders.
module berger_zero_count #(
  parameter int DATA_W = 12,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW-1:0]     zeros
);
  localparam int LVL = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int NL  = 1 << LVL;

  logic [CW-1:0] node [0:2*NL-2];

  for (genvar i = 0; i < NL; i++) begin : g_leaf
    if (i < DATA_W) begin : g_real
      assign node[NL-1+i] = {{(CW-1){1'b0}}, ~data[i]};
    end else begin : g_pad
      assign node[NL-1+i] = '0;
    end
  end

  for (genvar k = 0; k < NL-1; k++) begin : g_sum
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign zeros = node[0];
endmodule

// File: rtl/two_rail_tree.sv
// Equality check of two code words through a tree of two-pair two-rail cells.
module two_rail_tree #(
  parameter int W = 4
) (
  input  logic [W-1:0] codeA,
  input  logic [W-1:0] codeB,
  output logic [1:0]   rails
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;
  localparam int NP  = 1 << LVL;

  logic [2*NP-2:0] xr;
  logic [2*NP-2:0] yr;

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < W) begin : g_real
      assign xr[NP-1+i] = codeA[i];
      assign yr[NP-1+i] = ~codeB[i];
    end else begin : g_pad
      assign xr[NP-1+i] = 1'b0;
      assign yr[NP-1+i] = 1'b1;
    end
  end

  for (genvar k = 0; k < NP-1; k++) begin : g_cell
    assign xr[k] = (xr[2*k+1] & xr[2*k+2]) | (yr[2*k+1] & yr[2*k+2]);
    assign yr[k] = (xr[2*k+1] & yr[2*k+2]) | (yr[2*k+1] & xr[2*k+2]);
  end

  assign rails = {xr[0], yr[0]};
endmodule

// File: rtl/dup_regcnt_ctrl.sv
module dup_regcnt_ctrl
  import dup_regcnt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       decEn,
  output rcStrobe_t  strb
);
  logic liveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= 1'b0;
    else       liveQ <= loadEn;
  end

  always_comb begin
    strb.load      = loadEn;
    strb.dec       = decEn & ~loadEn;
    strb.checkLive = liveQ;
  end

  // R2: a load and a decrement are never issued together
  p_no_dec_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> (strb.load && !strb.dec));

  // R6: a decrement is never followed by a check cycle
  p_no_check_after_dec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (decEn && !loadEn) |=> !strb.checkLive);
endmodule

// File: rtl/dup_regcnt_dp.sv
module dup_regcnt_dp
  import dup_regcnt_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int CHK_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcStrobe_t         strb,
  input  logic [DATA_W-1:0] extData,
  input  logic [CHK_W-1:0]  extChk,
  output logic [DATA_W-1:0] valueOut,
  output logic              zeroA,
  output logic              nonZeroB,
  output logic [1:0]        chkPair
);
  localparam logic [CHK_W-1:0] RESET_CHK = CHK_W'(DATA_W);
  localparam logic [1:0]       IDLE_RAIL = 2'b01;

  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [CHK_W-1:0]  chkA;
  logic [CHK_W-1:0]  rebuiltChk;
  logic [1:0]        treeRails;

  // copy 1: information plus stored check bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      chkA <= RESET_CHK;
    end else if (strb.load) begin
      regA <= extData;
      chkA <= extChk;
    end else if (strb.dec) begin
      regA <= regA - 1'b1;
    end
  end

  // copy 2: information only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regB <= '0;
    else if (strb.load) regB <= extData;
    else if (strb.dec)  regB <= regB - 1'b1;
  end

  berger_zero_count #(.DATA_W(DATA_W)) u_gen (
    .data  (regB),
    .zeros (rebuiltChk)
  );

  two_rail_tree #(.W(CHK_W)) u_cmp (
    .codeA (chkA),
    .codeB (rebuiltChk),
    .rails (treeRails)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               chkPair <= IDLE_RAIL;
    else if (strb.checkLive) chkPair <= treeRails;
    else                     chkPair <= IDLE_RAIL;
  end

  assign valueOut = regA;
  assign zeroA    = (regA == '0);
  assign nonZeroB = |regB;

  // R2: a load fills both copies with the external word
  p_load_copies_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (regA == $past(extData)) && (regB == $past(extData)));

  // R3: a decrement steps both copies down by one
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |=> (regA == $past(regA) - 1'b1) && (regB == $past(regB) - 1'b1));

  // R4: without a command both copies hold
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.dec) |=> ($stable(regA) && $stable(regB) && $stable(chkA)));

  // R6: outside check cycles the result rails show the idle code
  p_idle_rail_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.checkLive |=> (chkPair == IDLE_RAIL));

  // R7: zero rails from the two copies stay complementary
  p_zero_rails_r7: assert property (@(posedge clk) disable iff (!rstN)
    zeroA != nonZeroB);
endmodule

// File: rtl/dup_regcnt.sv
module dup_regcnt
  import dup_regcnt_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int CHK_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic              decEn,
  input  logic [DATA_W-1:0] extData,
  input  logic [CHK_W-1:0]  extChk,
  output logic [DATA_W-1:0] valueOut,
  output logic              zeroA,
  output logic              nonZeroB,
  output logic [1:0]        chkPair
);
  rcStrobe_t strb;

  dup_regcnt_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .loadEn (loadEn),
    .decEn  (decEn),
    .strb   (strb)
  );

  dup_regcnt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .extData  (extData),
    .extChk   (extChk),
    .valueOut (valueOut),
    .zeroA    (zeroA),
    .nonZeroB (nonZeroB),
    .chkPair  (chkPair)
  );
endmodule

// File: tb/dup_regcnt_tb.sv
`timescale 1ns/1ps
module dup_regcnt_tb;
  localparam int DW = 12;
  localparam int CW = 4;
  localparam int NVEC = 8;

  // each entry: {data, check bits supplied}
  localparam logic [DW+CW-1:0] VEC [0:NVEC-1] = '{
    {12'h000, 4'd12}, {12'hFFF, 4'd0}, {12'h0F0, 4'd8}, {12'hA5A, 4'd6},
    {12'h001, 4'd11}, {12'h800, 4'd11}, {12'h123, 4'd7}, {12'hFFE, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic decEn = 1'b0;
  logic [DW-1:0] extData = '0;
  logic [CW-1:0] extChk = '0;
  logic [DW-1:0] valueOut;
  logic zeroA, nonZeroB;
  logic [1:0] chkPair;
  int nChecks = 0;
  int nFails = 0;

  dup_regcnt u_dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .decEn(decEn),
    .extData(extData), .extChk(extChk), .valueOut(valueOut),
    .zeroA(zeroA), .nonZeroB(nonZeroB), .chkPair(chkPair)
  );

  always #2 clk = ~clk;

  function automatic int zeroCount(logic [DW-1:0] d);
    int n = 0;
    for (int i = 0; i < DW; i++) if (!d[i]) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkValue(input string req, input logic [DW-1:0] exp);
    check(valueOut == exp, req, "valueOut", int'(valueOut), int'(exp));
    check(zeroA == (exp == 0), "R7", "zeroA", int'(zeroA), int'(exp == 0));
    check(nonZeroB == (exp != 0), "R7", "nonZeroB", int'(nonZeroB), int'(exp != 0));
  endtask

  // load a word, then check the value, the check result and the return to idle
  task automatic loadAndCheck(input string req, input logic [DW-1:0] d,
                              input logic [CW-1:0] c);
    bit expErr = (int'(c) != zeroCount(d));
    loadEn = 1'b1; extData = d; extChk = c;
    tick();
    loadEn = 1'b0; extData = ~d; extChk = ~c;
    checkValue("R2", d);
    tick();
    check((chkPair[0] == chkPair[1]) == expErr, req, "chkPair", int'(chkPair),
          expErr ? 0 : 1);
    tick();
    check(chkPair == 2'b01, "R6", "chkPair idle", int'(chkPair), 1);
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    checkValue("R1", '0);
    check(chkPair == 2'b01, "R1", "chkPair reset", int'(chkPair), 1);
    rstN = 1'b1;
    tick();
    check(chkPair == 2'b01, "R1", "chkPair after reset", int'(chkPair), 1);

    // R5: table of words with correct and wrong check bits
    for (int v = 0; v < NVEC; v++)
      loadAndCheck("R5", VEC[v][DW+CW-1:CW], VEC[v][CW-1:0]);

    // R8: each single flipped check bit is reported
    for (int b = 0; b < CW; b++)
      loadAndCheck("R8", 12'h3C5, CW'(zeroCount(12'h3C5)) ^ CW'(1 << b));

    // R3: decrement, then wrap through zero
    loadAndCheck("R5", 12'h002, 4'd11);
    decEn = 1'b1;
    tick();
    checkValue("R3", 12'h001);
    check(chkPair == 2'b01, "R6", "chkPair on decrement", int'(chkPair), 1);
    tick();
    checkValue("R3", 12'h000);
    tick();
    checkValue("R3", 12'hFFF);
    decEn = 1'b0;
    tick();
    check(chkPair == 2'b01, "R6", "chkPair after decrements", int'(chkPair), 1);

    // R4: hold with data inputs toggling
    extData = 12'h555; extChk = 4'd3;
    tick();
    tick();
    checkValue("R4", 12'hFFF);

    // R2: load wins over decrement
    loadEn = 1'b1; decEn = 1'b1; extData = 12'h040; extChk = 4'd11;
    tick();
    loadEn = 1'b0; decEn = 1'b0;
    checkValue("R2", 12'h040);
    tick();
    check(chkPair[0] != chkPair[1], "R5", "chkPair load+dec", int'(chkPair), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule